// File: doc/BRIEF.md
# Slice-Folded Keccak-f[1600] Permutation Core

This block applies the 24-round Keccak-f[1600] permutation, the fixed 1600-bit state transform used by the SHA-3 hash family, to one state at a time. It does not handle the whole 5x5x64 state in each cycle. It works on a group of adjacent slices (all 25 bits that share one z position) per cycle. With the default group of 16 slices, one sweep over the state takes four cycles.

Each round is evaluated in a rotated order: rho, pi, chi, iota, and then theta. The round is split into two folded sweeps. One sweep covers pi, chi and iota, which only ever look inside a single slice. The other sweep covers theta, which carries column parities from one slice to the next. This carry is passed between groups, and it wraps from slice 63 back to slice 0. Rho needs no gates. The theta sweep writes each lane into the state store already rotated by that lane's offset, so a plain read of slice z returns the rho result. To keep the overall result equal to the standard permutation, one theta sweep runs before round 1 and the theta after round 24 is dropped.

A user places a state on `state_in` and pulses `start` while the core is idle. The user then waits for `done` and reads `state_out`. `done` and the result stay put until the next accepted start. There is no back-pressure: `start` is a plain control pin, and a start that arrives while the core is busy is simply ignored.

Top module: `kslice_perm`

## Requirements
- R1: `state_out` equals the standard Keccak-f[1600] permutation of the `state_in` captured at the accepting start. Both vectors hold lane (x,y) in bits [64*(x+5y)+63 : 64*(x+5y)], and bit z of that lane sits at 64*(x+5y)+z.
- R2: For an all-zero input, lane (0,0) of the result, which is `state_out[63:0]`, is 64'hF1258F7940E1DDE7.
- R3: A start sampled while `busy` is low is accepted. After that edge, `busy` is 1 and `done` is 0.
- R4: `done` rises, and `busy` falls, on the 192nd clock edge after the accepting edge. This is 48 sweeps of 4 slice groups: one leading theta sweep, 24 pi/chi/iota sweeps and 23 theta sweeps.
- R5: A start sampled while `busy` is high has no effect. This includes a start on the final busy edge. The pending result, its latency, and the `done` state that follows are all unchanged.
- R6: While no start is sampled, `done` stays high and `state_out` stays stable.
- R7: While reset is asserted, `busy` and `done` are 0.
- R8: `busy` and `done` are never high together.
- R9: A start sampled while `done` is high begins a new permutation. Its result depends only on the new input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a permutation; only sampled while idle |
| state_in | input | 1600 | Input state, lane (x,y) at bits 64*(x+5y) upward |
| busy | output | 1 | Permutation in progress |
| done | output | 1 | Result valid; held until the next accepted start |
| state_out | output | 1600 | Permuted state, same lane layout as the input |

## Verification
Completion and a new request can coincide. A start pulse can land on the very edge where the last pi/chi/iota group is written and `done` rises. The bench counts edges from acceptance and pulses `start`, with a different state, exactly on edge 192. It passes only if `done` rises on that edge, the result matches the first state's reference, and `done` is still high several cycles later with no restart. A start dropped into the middle of a run is judged the same way, by the unchanged result and unchanged latency.

// File: rtl/kslice_pkg.sv
package kslice_pkg;
  localparam int LW     = 64;
  localparam int NLANE  = 25;
  localparam int NROUND = 24;

  // per-lane rotation, index x+5y; applied through the write address of the store
  localparam int RHO [NLANE] = '{ 0,  1, 62, 28, 27,
                                 36, 44,  6, 55, 20,
                                  3, 10, 43, 25, 39,
                                 41, 45, 15, 21,  8,
                                 18,  2, 61, 56, 14};

  // all round constants, round r at bits [r*LW +: LW], produced by the 8-bit LFSR
  function automatic logic [NROUND*LW-1:0] rc_table();
    logic [NROUND*LW-1:0] tab;
    logic [7:0] lf;
    tab = '0;
    lf  = 8'h01;
    for (int n = 0; n < NROUND*7; n++) begin
      if (lf[0]) tab[(n/7)*LW + (1 << (n%7)) - 1] = 1'b1;
      lf = lf[7] ? ({lf[6:0], 1'b0} ^ 8'h71) : {lf[6:0], 1'b0};
    end
    return tab;
  endfunction
endpackage

// File: rtl/kslice_theta_grp.sv
module kslice_theta_grp #(
  parameter int G = 16
) (
  input  logic [G-1:0][24:0] s_in,
  input  logic [4:0]         par_prev,
  output logic [G-1:0][24:0] s_out,
  output logic [4:0]         par_last
);
  logic [G-1:0][4:0] pc;

  for (genvar k = 0; k < G; k++) begin : g_sl
    logic [4:0] pp;
    for (genvar x = 0; x < 5; x++) begin : g_par
      assign pc[k][x] = s_in[k][x] ^ s_in[k][x+5] ^ s_in[k][x+10] ^
                        s_in[k][x+15] ^ s_in[k][x+20];
    end
    // slice z draws on the parities of slice z-1; the first slice uses the carry
    if (k == 0) begin : g_first
      assign pp = par_prev;
    end else begin : g_rest
      assign pp = pc[k-1];
    end
    for (genvar y = 0; y < 5; y++) begin : g_y
      for (genvar x = 0; x < 5; x++) begin : g_x
        assign s_out[k][x+5*y] = s_in[k][x+5*y] ^ pc[k][(x+4)%5] ^ pp[(x+1)%5];
      end
    end
  end

  assign par_last = pc[G-1];
endmodule

// File: rtl/kslice_pci_grp.sv
module kslice_pci_grp #(
  parameter int G = 16
) (
  input  logic [G-1:0][24:0] s_in,
  input  logic [G-1:0]       rc,
  output logic [G-1:0][24:0] s_out
);
  for (genvar k = 0; k < G; k++) begin : g_sl
    logic [24:0] b;
    for (genvar yy = 0; yy < 5; yy++) begin : g_pi_y
      for (genvar xx = 0; xx < 5; xx++) begin : g_pi_x
        assign b[xx+5*yy] = s_in[k][(xx+3*yy)%5 + 5*xx];
      end
    end
    for (genvar y = 0; y < 5; y++) begin : g_y
      for (genvar x = 0; x < 5; x++) begin : g_x
        if (x == 0 && y == 0) begin : g_iota
          assign s_out[k][0] = b[0] ^ (~b[1] & b[2]) ^ rc[k];
        end else begin : g_chi
          assign s_out[k][x+5*y] = b[x+5*y] ^ (~b[(x+1)%5+5*y] & b[(x+2)%5+5*y]);
        end
      end
    end
  end
endmodule

// File: rtl/kslice_rc_sel.sv
module kslice_rc_sel #(
  parameter int G  = 16,
  parameter int GW = 2
) (
  input  logic [4:0]    rnd,
  input  logic [GW-1:0] grp,
  output logic [G-1:0]  rc
);
  import kslice_pkg::*;
  localparam logic [NROUND*LW-1:0] RC_TAB = rc_table();

  // only the constant bits that fall on this group's z positions
  assign rc = RC_TAB[int'(rnd)*LW + int'(grp)*G +: G];
endmodule

// File: rtl/kslice_perm.sv
module kslice_perm #(
  parameter int G = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1599:0] state_in,
  output logic         busy,
  output logic         done,
  output logic [1599:0] state_out
);
  import kslice_pkg::*;
  localparam int NG  = LW / G;
  localparam int GW  = (NG > 1) ? $clog2(NG) : 1;
  localparam int LAT = 48 * NG;

  typedef enum logic [1:0] {PH_IDLE, PH_THETA, PH_PCI} phase_t;

  phase_t            phase;
  logic [GW-1:0]     grp;
  logic [4:0]        rnd;
  logic [4:0]        carry_q;
  logic              done_q;
  logic [LW-1:0]     mem  [NLANE];
  logic [LW-1:0]     work [NLANE];
  logic [G-1:0][24:0] th_in, th_out, pc_in, pc_out;
  logic [4:0]        par_prev, par_last, par_wrap;
  logic [G-1:0]      rc_bits;
  logic              last_grp;

  assign last_grp = (grp == GW'(NG-1));
  assign busy     = (phase != PH_IDLE);
  assign done     = done_q;

  always_comb begin
    for (int k = 0; k < G; k++) begin
      for (int i = 0; i < NLANE; i++) begin
        th_in[k][i] = work[i][6'(int'(grp)*G + k)];
        pc_in[k][i] = mem[i][6'(int'(grp)*G + k)];
      end
    end
    for (int x = 0; x < 5; x++)
      par_wrap[x] = work[x][LW-1] ^ work[x+5][LW-1] ^ work[x+10][LW-1] ^
                    work[x+15][LW-1] ^ work[x+20][LW-1];
    // group 0 wraps to slice 63; later groups use the carried parity
    par_prev = (grp == '0) ? par_wrap : carry_q;
    for (int i = 0; i < NLANE; i++) state_out[i*LW +: LW] = work[i];
  end

  kslice_theta_grp #(.G(G)) u_theta (
    .s_in(th_in), .par_prev(par_prev), .s_out(th_out), .par_last(par_last));

  kslice_rc_sel #(.G(G), .GW(GW)) u_rc (
    .rnd(rnd), .grp(grp), .rc(rc_bits));

  kslice_pci_grp #(.G(G)) u_pci (
    .s_in(pc_in), .rc(rc_bits), .s_out(pc_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      grp     <= '0;
      rnd     <= '0;
      carry_q <= '0;
      done_q  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_THETA;
          grp    <= '0;
          rnd    <= '0;
          done_q <= 1'b0;
        end
        PH_THETA: begin
          carry_q <= par_last;
          if (last_grp) begin
            grp   <= '0;
            phase <= PH_PCI;
          end else grp <= grp + 1'b1;
        end
        PH_PCI: begin
          if (last_grp) begin
            grp <= '0;
            if (rnd == 5'(NROUND-1)) begin
              phase  <= PH_IDLE;
              done_q <= 1'b1;
            end else begin
              rnd   <= rnd + 1'b1;
              phase <= PH_THETA;
            end
          end else grp <= grp + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // working copy: loaded at start, rewritten slice group by slice group by pi/chi/iota
  always_ff @(posedge clk) begin
    if (phase == PH_IDLE && start) begin
      for (int i = 0; i < NLANE; i++) work[i] <= state_in[i*LW +: LW];
    end else if (phase == PH_PCI) begin
      for (int k = 0; k < G; k++)
        for (int i = 0; i < NLANE; i++)
          work[i][6'(int'(grp)*G + k)] <= pc_out[k][i];
    end
  end

  // state store: theta output is written at z + offset, so reads return the rho result
  always_ff @(posedge clk) begin
    if (phase == PH_THETA) begin
      for (int i = 0; i < NLANE; i++)
        for (int k = 0; k < G; k++)
          mem[i][6'(int'(grp)*G + k + RHO[i])] <= th_out[k][i];
    end
  end

  // edge counter used only by the latency assertion
  logic [15:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat_cnt <= '0;
    else if (start && !busy)   lat_cnt <= '0;
    else if (busy)             lat_cnt <= lat_cnt + 1'b1;
  end

  assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);
  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> lat_cnt == 16'(LAT));
  assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> busy || done);
  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(state_out));
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

// File: tb/kslice_perm_tb.sv
module kslice_perm_tb;
  localparam int CLK_P = 10;
  localparam int LAT   = 192;
  localparam int WD    = 20000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [1599:0] state_in;
  logic         busy, done;
  logic [1599:0] state_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [1599:0] exp_q [$];
  logic [1599:0] last_exp;
  logic done_prev = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  kslice_perm u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .state_in(state_in),
    .busy(busy), .done(done), .state_out(state_out));

  function automatic logic [63:0] rotl(input logic [63:0] v, input int n);
    return (n == 0) ? v : ((v << n) | (v >> (64 - n)));
  endfunction

  // standard theta-first reference permutation
  function automatic logic [1599:0] ref_perm(input logic [1599:0] s);
    logic [63:0] a [25];
    logic [63:0] b [25];
    logic [63:0] c [5];
    logic [63:0] d, rcv;
    int rot [25];
    int px, py, nx;
    logic [7:0] lf;
    logic [1599:0] r;
    for (int i = 0; i < 25; i++) a[i] = s[i*64 +: 64];
    rot[0] = 0; px = 1; py = 0;
    for (int t = 0; t < 24; t++) begin
      rot[px+5*py] = ((t+1)*(t+2)/2) % 64;
      nx = py; py = (2*px + 3*py) % 5; px = nx;
    end
    lf = 8'h01;
    for (int rn = 0; rn < 24; rn++) begin
      for (int x = 0; x < 5; x++) c[x] = a[x]^a[x+5]^a[x+10]^a[x+15]^a[x+20];
      for (int x = 0; x < 5; x++) begin
        d = c[(x+4)%5] ^ rotl(c[(x+1)%5], 1);
        for (int y = 0; y < 5; y++) a[x+5*y] ^= d;
      end
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          b[y + 5*((2*x+3*y)%5)] = rotl(a[x+5*y], rot[x+5*y]);
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          a[x+5*y] = b[x+5*y] ^ (~b[(x+1)%5+5*y] & b[(x+2)%5+5*y]);
      rcv = '0;
      for (int j = 0; j < 7; j++) begin
        if (lf[0]) rcv[(1 << j) - 1] = 1'b1;
        lf = {lf[6:0], 1'b0} ^ (lf[7] ? 8'h71 : 8'h00);
      end
      a[0] ^= rcv;
    end
    for (int i = 0; i < 25; i++) r[i*64 +: 64] = a[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [1599:0] act, input logic [1599:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1599:0] rnd_state();
    logic [1599:0] s;
    for (int i = 0; i < 50; i++) s[i*32 +: 32] = $urandom;
    return s;
  endfunction

  // monitor: pops the expected result when done rises (R1)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done && !done_prev) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected result", state_out, '0);
      else begin
        logic [1599:0] e;
        e = exp_q.pop_front();
        chk(state_out === e, "R1 permutation result", state_out, e);
      end
    end
    done_prev = done;
  end

  // driver: pushes the expected item, launches, optionally pokes a start at edge poke_at+1
  task automatic run_one(input logic [1599:0] s, input int poke_at,
                         input logic [1599:0] poke_s, output int lat);
    int cnt;
    last_exp = ref_perm(s);
    exp_q.push_back(last_exp);
    @(negedge clk); state_in = s; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done, "R3 accept", {1598'd0, busy, done}, {1598'd0, 2'b10});
    cnt = 0;
    while (!done) begin
      start = (cnt == poke_at);
      if (start) state_in = poke_s;
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    lat = cnt;
    chk(lat == LAT, "R4 latency", 1600'(lat), 1600'(LAT));
    chk(!busy, "R8 busy low with done", {1599'd0, busy}, '0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lat;
    logic [1599:0] sa;
    rst_n = 1'b0; start = 1'b0; state_in = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R7 reset state", {1598'd0, busy, done}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // all-zero input
    run_one('0, -1, '0, lat);
    chk(state_out[63:0] === 64'hF1258F7940E1DDE7, "R2 zero known answer",
        {1536'd0, state_out[63:0]}, {1536'd0, 64'hF1258F7940E1DDE7});
    repeat (10) @(negedge clk);
    chk(done && state_out === last_exp, "R6 hold", state_out, last_exp);

    // random states back to back while done is high
    for (int n = 0; n < 3; n++) begin
      run_one(rnd_state(), -1, '0, lat);
      chk(state_out === last_exp, "R9 restart from done", state_out, last_exp);
    end

    // start in the middle of a run is ignored
    sa = rnd_state();
    run_one(sa, 50, rnd_state(), lat);
    chk(state_out === ref_perm(sa), "R5 mid-run start ignored", state_out, ref_perm(sa));

    // start on the final busy edge is ignored
    sa = rnd_state();
    run_one(sa, LAT-1, rnd_state(), lat);
    repeat (4) @(negedge clk);
    chk(done && !busy, "R5 last-edge start ignored", {1598'd0, busy, done}, {1598'd0, 2'b01});
    chk(state_out === ref_perm(sa), "R5 result kept", state_out, ref_perm(sa));

    chk(exp_q.size() == 0, "R1 all results seen", 1600'(exp_q.size()), '0);
    finish_run();
  end
endmodule